// File: doc/BRIEF.md
# BCD Hour Counter with 12/24 Mode

This block holds the hour field of a real-time clock as one packed BCD byte and moves it forward by one hour each time the hour-tick input is high on a clock edge. A bit in the control byte selects the counting scheme. In 24-hour mode the byte runs from 00 to 23. In 12-hour mode bit 5 of the byte is the PM marker, so afternoon hours read 20 above their 12-hour value. When the count wraps at the end of a day, the block emits a one-cycle carry pulse for a day counter downstream.

The same control byte also stores the two alarm enable bits, a clock-output disable bit, a test bit and a three-bit periodic-interrupt select. These bits are stored here and are decoded by neighbouring logic. An oscillator-stop flag clears the control byte. Software loads the hour and the control byte through plain synchronous write strobes. Both write ports always accept data, so there is no back-pressure. The write enable is the valid signal, and no ready signal is needed.

Top module: `rtc_hour_unit`

## Requirements
- R1: With the mode bit at 1, successive ticks step the hour byte through BCD 00, 01 … 09, 10 … 19, 20 … 23 and then back to 00.
- R2: With the mode bit at 0, successive ticks step the hour byte through 12, 01 … 11, 32, 21 … 31 and then back to 12. Bit 5 (0x20) is the PM marker.
- R3: Control byte bit 5 is the mode bit: 0 selects 12-hour and 1 selects 24-hour. Changing it does not rewrite the stored hour.
- R4: day_carry is high for exactly one cycle when a tick wraps the hour from 23 to 00 (24-hour) or from 31 to 12 (12-hour). It is high in the cycle that shows the new hour and never at any other time.
- R5: A hour write in the same cycle as a tick wins, and the tick is lost. Written values are stored exactly as given, with no range check.
- R6: While osc_stop is high, the control byte clears to 0x00 on the clock edge, even if a control write is present. The hour byte is unaffected.
- R7: clk_out follows clk32_in when ctrl bit 4 or clk_dis_ext is 0. It is held at 1 when both are 1.
- R8: Control byte layout: bit 7 drives wk_alarm_en, bit 6 drives day_alarm_en, bit 5 is the mode bit, bit 4 is a clock-output disable, bit 3 is test, and bits 2:0 are the periodic select. All eight bits read back as written.
- R9: After reset the hour byte is 0x12, the control byte is 0x00 and day_carry is 0.
- R10: With no tick and no hour write, the hour byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low synchronous reset |
| osc_stop | input | 1 | oscillator-stop flag, clears control byte |
| hour_tick | input | 1 | advance hour by one on this edge |
| hour_wr | input | 1 | load hour_wdata into the hour byte |
| hour_wdata | input | 8 | hour value to load, packed BCD |
| ctrl_wr | input | 1 | load ctrl_wdata into the control byte |
| ctrl_wdata | input | 8 | control byte value to load |
| clk_dis_ext | input | 1 | second active-low clock-output enable from elsewhere |
| clk32_in | input | 1 | 32 kHz oscillator clock |
| hour_q | output | 8 | current hour byte |
| ctrl_q | output | 8 | current control byte |
| mode_24 | output | 1 | 1 when counting in 24-hour mode |
| wk_alarm_en | output | 1 | weekly alarm enable |
| day_alarm_en | output | 1 | daily alarm enable |
| day_carry | output | 1 | one-cycle pulse at day rollover |
| clk_out | output | 1 | gated 32 kHz output, high when disabled |

## Verification
The counter is walked through a full day in each mode. This checks every BCD nibble carry, the 11-to-12 PM toggle and that the wrap and carry pulse appear only at 23 and 31. The mode bit is then flipped with a loaded hour, which shows whether the hour is wrongly translated. Collisions of a write and a tick show which one wins. Out-of-range writes show that no clamping is done. The four combinations of the two clock-output disable bits, each with both input levels, show gating versus holding high. An oscillator stop that coincides with a control write shows that the clear takes priority.

// File: rtl/rtc_hour_pkg.sv
package rtc_hour_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PM_BIT = 5;
  localparam int unsigned SEL_W  = 3;

  typedef struct packed {
    logic             wk_alarm;
    logic             day_alarm;
    logic             mode24;
    logic             clk_dis;
    logic             test;
    logic [SEL_W-1:0] per_sel;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] HOUR_RESET = 8'h12;
  localparam logic [BYTE_W-1:0] LAST_24    = 8'h23;
endpackage

// File: rtl/rtc_hour_ctrl.sv
module rtc_hour_ctrl
  import rtc_hour_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_stop,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (!rst_n || osc_stop) ctrl <= '0;
    else if (wr)            ctrl <= ctrl_t'(wdata);
  end

  p_osc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> (ctrl == '0));
  p_ctrl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !osc_stop) |=> (ctrl == ctrl_t'($past(wdata))));
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_hour_pkg::*;
#(
  parameter int unsigned PM_POS = PM_BIT
) (
  input  logic              mode24,
  input  logic [BYTE_W-1:0] cur,
  output logic [BYTE_W-1:0] nxt,
  output logic              wrap
);
  localparam logic [BYTE_W-1:0] PM_MASK = BYTE_W'(1) << PM_POS;

  logic              pm;
  logic [BYTE_W-1:0] hr;
  logic [BYTE_W-1:0] pm_bits;

  assign pm      = cur[PM_POS];
  assign hr      = cur & ~PM_MASK;
  assign pm_bits = pm ? PM_MASK : '0;

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (mode24) begin
      if (cur == LAST_24) begin
        nxt  = '0;
        wrap = 1'b1;
      end else if (cur[3:0] == 4'h9) begin
        nxt = {cur[7:4] + 4'h1, 4'h0};
      end else begin
        nxt = {cur[7:4], cur[3:0] + 4'h1};
      end
    end else begin
      if (hr == 8'h12) begin
        nxt = 8'h01 | pm_bits;
      end else if (hr == 8'h11) begin
        nxt  = pm ? 8'h12 : (8'h12 | PM_MASK);
        wrap = pm;
      end else if (hr[3:0] == 4'h9) begin
        nxt = {hr[7:4] + 4'h1, 4'h0} | pm_bits;
      end else begin
        nxt = {hr[7:4], hr[3:0] + 4'h1} | pm_bits;
      end
    end
  end
endmodule

// File: rtl/rtc_hour_clkout.sv
module rtc_hour_clkout (
  input  logic dis_a,
  input  logic dis_b,
  input  logic clk_in,
  output logic active,
  output logic clk_out
);
  assign active  = !(dis_a && dis_b);
  assign clk_out = active ? clk_in : 1'b1;
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit
  import rtc_hour_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_stop,
  input  logic              hour_tick,
  input  logic              hour_wr,
  input  logic [BYTE_W-1:0] hour_wdata,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] ctrl_wdata,
  input  logic              clk_dis_ext,
  input  logic              clk32_in,
  output logic [BYTE_W-1:0] hour_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              mode_24,
  output logic              wk_alarm_en,
  output logic              day_alarm_en,
  output logic              day_carry,
  output logic              clk_out
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] hour_r;
  logic [BYTE_W-1:0] hour_nxt;
  logic              wrap;
  logic              carry_r;
  logic              clk_active;

  rtc_hour_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .osc_stop (osc_stop),
    .wr    (ctrl_wr),
    .wdata (ctrl_wdata),
    .ctrl  (ctrl)
  );

  rtc_hour_step #(.PM_POS(PM_BIT)) u_step (
    .mode24 (ctrl.mode24),
    .cur    (hour_r),
    .nxt    (hour_nxt),
    .wrap   (wrap)
  );

  rtc_hour_clkout u_clk (
    .dis_a   (ctrl.clk_dis),
    .dis_b   (clk_dis_ext),
    .clk_in  (clk32_in),
    .active  (clk_active),
    .clk_out (clk_out)
  );

  // Write wins over tick (R5); carry only from a tick that wraps (R4)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hour_r  <= HOUR_RESET;
      carry_r <= 1'b0;
    end else begin
      carry_r <= hour_tick && !hour_wr && wrap;
      if (hour_wr)        hour_r <= hour_wdata;
      else if (hour_tick) hour_r <= hour_nxt;
    end
  end

  assign hour_q       = hour_r;
  assign ctrl_q       = ctrl;
  assign mode_24      = ctrl.mode24;
  assign wk_alarm_en  = ctrl.wk_alarm;
  assign day_alarm_en = ctrl.day_alarm;
  assign day_carry    = carry_r;

  p_carry_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> (hour_q == 8'h00 || hour_q == 8'h12));
  p_carry_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> !day_carry);
  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hour_wr |=> (hour_q == $past(hour_wdata)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hour_tick && !hour_wr) |=> $stable(hour_q));
  p_clk_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_active |-> clk_out);
endmodule

// File: tb/rtc_hour_unit_test.sv
module rtc_hour_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_stop = 1'b0;
  logic hour_tick = 1'b0;
  logic hour_wr = 1'b0;
  logic [7:0] hour_wdata = 8'h00;
  logic ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic clk_dis_ext = 1'b1;
  logic clk32_in = 1'b0;
  logic [7:0] hour_q, ctrl_q;
  logic mode_24, wk_alarm_en, day_alarm_en, day_carry, clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_hour_unit uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] exp12(input int k);
    int h = k % 12;
    if (h == 0) h = 12;
    return to_bcd(h) + ((k >= 12) ? 8'h20 : 8'h00);
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_tick();
    hour_tick = 1'b1; cyc(); hour_tick = 1'b0;
  endtask

  task automatic wr_hour(input logic [7:0] v);
    hour_wr = 1'b1; hour_wdata = v; cyc(); hour_wr = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v; cyc(); ctrl_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 hour", hour_q, 8'h12);
    chk("R9 ctrl", ctrl_q, 8'h00);
    chk("R9 carry", {7'b0, day_carry}, 8'h00);
  endtask

  task automatic t_day24();
    int cnt = 0;
    wr_ctrl(8'h20);
    chk("R3 mode bit", {7'b0, mode_24}, 8'h01);
    wr_hour(8'h00);
    for (int i = 1; i <= 24; i++) begin
      do_tick();
      chk("R1 step", hour_q, to_bcd(i % 24));
      if (day_carry) cnt++;
      if (i == 24) chk("R4 carry 23->00", {7'b0, day_carry}, 8'h01);
    end
    cyc();
    chk("R4 one cycle", {7'b0, day_carry}, 8'h00);
    chk("R4 count", 8'(cnt), 8'h01);
  endtask

  task automatic t_day12();
    int cnt = 0;
    wr_ctrl(8'h00);
    wr_hour(8'h12);
    for (int k = 1; k <= 24; k++) begin
      do_tick();
      chk("R2 step", hour_q, exp12(k % 24));
      if (day_carry) cnt++;
      if (k == 24) chk("R4 carry 31->12", {7'b0, day_carry}, 8'h01);
    end
    cyc();
    chk("R4 one cycle 12h", {7'b0, day_carry}, 8'h00);
    chk("R4 count 12h", 8'(cnt), 8'h01);
  endtask

  task automatic t_mode_switch();
    wr_hour(8'h15);
    wr_ctrl(8'h00);
    chk("R3 no translate", hour_q, 8'h15);
    wr_ctrl(8'h20);
    chk("R3 no translate back", hour_q, 8'h15);
  endtask

  task automatic t_write_prio();
    wr_ctrl(8'h20);
    wr_hour(8'h05);
    hour_tick = 1'b1; hour_wr = 1'b1; hour_wdata = 8'h23; cyc();
    hour_tick = 1'b0; hour_wr = 1'b0;
    chk("R5 write wins", hour_q, 8'h23);
    chk("R5 no carry", {7'b0, day_carry}, 8'h00);
    wr_hour(8'h3F);
    chk("R5 no range check", hour_q, 8'h3F);
    wr_hour(8'h23);
  endtask

  task automatic t_hold();
    wr_hour(8'h07);
    repeat (5) cyc();
    chk("R10 hold", hour_q, 8'h07);
  endtask

  task automatic t_osc();
    wr_ctrl(8'hFF);
    chk("R8 readback", ctrl_q, 8'hFF);
    chk("R8 alarm enables", {6'b0, wk_alarm_en, day_alarm_en}, 8'h03);
    osc_stop = 1'b1; ctrl_wr = 1'b1; ctrl_wdata = 8'hAA; cyc();
    osc_stop = 1'b0; ctrl_wr = 1'b0;
    chk("R6 clear", ctrl_q, 8'h00);
    chk("R6 hour kept", hour_q, 8'h07);
    wr_ctrl(8'h8B);
    chk("R8 readback 2", ctrl_q, 8'h8B);
    chk("R8 enables 2", {6'b0, wk_alarm_en, day_alarm_en}, 8'h02);
  endtask

  task automatic t_clkout();
    for (int m = 0; m < 4; m++) begin
      wr_ctrl((m & 1) ? 8'h10 : 8'h00);
      clk_dis_ext = (m & 2) ? 1'b1 : 1'b0;
      for (int lv = 0; lv < 2; lv++) begin
        clk32_in = lv[0];
        #1;
        chk("R7 clk out", {7'b0, clk_out}, (m == 3) ? 8'h01 : {7'b0, lv[0]});
      end
    end
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_day24();
    t_day12();
    t_mode_switch();
    t_write_prio();
    t_hold();
    t_osc();
    t_clkout();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule